// File: doc/BRIEF.md
# DC-Only Residual Offset Adder

When a coded block carries a single nonzero coefficient in the DC position, the full two-dimensional inverse transform collapses to adding one constant to every pixel of the block. This block takes that DC coefficient and the block shape. It applies two scale, round and shift stages that depend on the shape, which stand in for the gains of the row and column transforms. It then adds the resulting signed offset, saturating to the 8-bit pixel range, to each destination pixel as the rows stream through.

A block begins with a command beat that carries the DC value and the shape. The scaled offset is worked out in the cycle after the command is accepted. Destination rows then go in and come out at up to one row per cycle, with valid/ready handshakes on both sides. A row is always eight pixels wide on the bus. For four-pixel-wide shapes, the upper four pixels of the row pass through unchanged.

Top module: `dcadd_top`

## Requirements
- R1: After reset, cmd_ready is 1, row_in_ready is 0 and row_out_valid is 0.
- R2: cmd_size 0 selects 8 wide by 8 tall, with offset x = (3*dc + 1) >> 1 followed by (3*x + 16) >> 5.
- R3: cmd_size 1 selects 8 wide by 4 tall, with offset x = (3*dc + 1) >> 1 followed by (17*x + 64) >> 7.
- R4: cmd_size 2 selects 4 wide by 8 tall, with offset x = (17*dc + 4) >> 3 followed by (12*x + 64) >> 7.
- R5: cmd_size 3 selects 4 wide by 4 tall, with offset x = (17*dc + 4) >> 3 followed by (17*x + 64) >> 7.
- R6: Every shift in R2 to R5 is arithmetic, so negative values round toward minus infinity. For example, dc = -7 with cmd_size 3 gives offset -2.
- R7: A pixel whose sum exceeds 255 becomes 255.
- R8: A pixel whose sum falls below 0 becomes 0.
- R9: In the four-wide shapes, pixels 4 to 7 of each row (bits 63:32) leave unchanged. Pixel k occupies bits 8k+7:8k.
- R10: A block takes exactly 4 or 8 rows, as its shape requires. row_out_last is 1 on the final row only, and after that row row_in_ready stays 0 until a new command arrives.
- R11: An output row is presented on the cycle after it is accepted. While row_out_valid is 1 and row_out_ready is 0, row_out_data and row_out_last hold, and no new row is accepted.
- R12: row_in_ready is 0 until a command has been accepted, and cmd_ready is 0 from the acceptance of a command until the last row of that block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_dc | input | DC_W | Signed DC coefficient |
| cmd_size | input | 2 | Block shape code (see R2 to R5) |
| row_in_valid | input | 1 | Destination row present |
| row_in_ready | output | 1 | Row accepted this cycle when valid |
| row_in_data | input | 64 | Eight 8-bit pixels, pixel k at bits 8k+7:8k |
| row_out_valid | output | 1 | Updated row present |
| row_out_ready | input | 1 | Downstream takes the row |
| row_out_data | output | 64 | Updated pixels, same layout as input |
| row_out_last | output | 1 | Marks the final row of the block |

## Verification
The bench builds the block with DC_W = 12, the default. At that width the coefficient extremes of 2047 and -2048 are within reach, and both drive the offset past the pixel range for every shape, so the saturating add and subtract are both exercised. Small negative coefficients show the floor rounding of the arithmetic shifts. Throttling the output side creates back-pressure that holds rows in the output stage and stalls row intake.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;

    localparam int PIX_W = 8;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef enum logic [1:0] {
        SZ_W8_H8 = 2'd0,
        SZ_W8_H4 = 2'd1,
        SZ_W4_H8 = 2'd2,
        SZ_W4_H4 = 2'd3
    } blk_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_STREAM = 2'd2
    } seq_state_e;

    // Offset split into an additive and a subtractive magnitude
    typedef struct packed {
        logic [PIX_W-1:0] add_mag;
        logic [PIX_W-1:0] sub_mag;
    } pix_offset_t;

    function automatic int rows_of(blk_size_e s);
        return (s == SZ_W8_H8 || s == SZ_W4_H8) ? 8 : 4;
    endfunction

    function automatic logic is_wide(blk_size_e s);
        return (s == SZ_W8_H8 || s == SZ_W8_H4);
    endfunction

    // one gain stage: multiply, add rounding term, arithmetic shift
    function automatic logic signed [31:0] gain_step(logic signed [31:0] x,
                                                     int mul, int rnd, int sh);
        logic signed [31:0] t;
        t = x * mul + rnd;
        return t >>> sh;
    endfunction

    function automatic logic [PIX_W-1:0] sat_offset(logic [PIX_W-1:0] p,
                                                    pix_offset_t o);
        logic [PIX_W:0]   up;
        logic [PIX_W-1:0] hi;
        up = {1'b0, p} + {1'b0, o.add_mag};
        hi = up[PIX_W] ? PIX_W'(PIX_MAX) : up[PIX_W-1:0];
        return (hi >= o.sub_mag) ? hi - o.sub_mag : '0;
    endfunction

endpackage

// File: rtl/dcadd_scaler.sv
module dcadd_scaler
    import dcadd_pkg::*;
#(
    parameter int DC_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic signed [DC_W-1:0] dc_in,
    input  logic                   load,
    input  blk_size_e              size,
    output pix_offset_t            off_q
);
    logic signed [DC_W-1:0] dc_q;
    logic signed [31:0]     dc_ext, s1, s2, neg_s2;
    pix_offset_t            off_d;

    assign dc_ext = 32'(dc_q);

    always_comb begin
        unique case (size)
            SZ_W8_H8: begin
                s1 = gain_step(dc_ext, 3, 1, 1);
                s2 = gain_step(s1, 3, 16, 5);
            end
            SZ_W8_H4: begin
                s1 = gain_step(dc_ext, 3, 1, 1);
                s2 = gain_step(s1, 17, 64, 7);
            end
            SZ_W4_H8: begin
                s1 = gain_step(dc_ext, 17, 4, 3);
                s2 = gain_step(s1, 12, 64, 7);
            end
            default: begin
                s1 = gain_step(dc_ext, 17, 4, 3);
                s2 = gain_step(s1, 17, 64, 7);
            end
        endcase
        neg_s2 = -s2;
        off_d.add_mag = '0;
        off_d.sub_mag = '0;
        if (s2 > PIX_MAX)      off_d.add_mag = PIX_W'(PIX_MAX);
        else if (s2 > 0)       off_d.add_mag = s2[PIX_W-1:0];
        if (neg_s2 > PIX_MAX)  off_d.sub_mag = PIX_W'(PIX_MAX);
        else if (neg_s2 > 0)   off_d.sub_mag = neg_s2[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q  <= '0;
            off_q <= '0;
        end else begin
            if (capture) dc_q  <= dc_in;
            if (load)    off_q <= off_d;
        end
    end

    // R7 R8
    off_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(off_q.add_mag != '0 && off_q.sub_mag != '0));

endmodule

// File: rtl/dcadd_row_stage.sv
module dcadd_row_stage
    import dcadd_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   accept,
    input  logic                   last_in,
    input  logic                   wide,
    input  pix_offset_t            off,
    input  logic [LANES*PIX_W-1:0] row_in,
    input  logic                   out_ready,
    output logic                   out_free,
    output logic                   out_valid,
    output logic                   out_last,
    output logic [LANES*PIX_W-1:0] out_data
);
    localparam int HALF = LANES / 2;
    localparam int ROW_W = LANES * PIX_W;

    logic [ROW_W-1:0] row_sum;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g < HALF) begin : g_always
                assign row_sum[g*PIX_W +: PIX_W] = sat_offset(row_in[g*PIX_W +: PIX_W], off);
            end else begin : g_wide_only
                assign row_sum[g*PIX_W +: PIX_W] =
                    wide ? sat_offset(row_in[g*PIX_W +: PIX_W], off) : row_in[g*PIX_W +: PIX_W];
            end
        end
    endgenerate

    assign out_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_last  <= last_in;
            out_data  <= row_sum;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R11
    accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R9
    narrow_pass_chk: assert property (@(posedge clk) disable iff (rst)
        accept && !wide |=> out_data[ROW_W-1:HALF*PIX_W] == $past(row_in[ROW_W-1:HALF*PIX_W]));

endmodule

// File: rtl/dcadd_sequencer.sv
module dcadd_sequencer
    import dcadd_pkg::*;
#(
    parameter int MAX_ROWS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  blk_size_e cmd_size,
    input  logic      row_in_valid,
    input  logic      out_free,
    output logic      cmd_ready,
    output logic      cmd_take,
    output logic      row_in_ready,
    output logic      scale_load,
    output logic      row_accept,
    output logic      row_is_last,
    output blk_size_e size_q
);
    localparam int CNT_W = $clog2(MAX_ROWS + 1);

    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q, rows_lim;

    assign rows_lim     = CNT_W'(rows_of(size_q));
    assign cmd_ready    = (st_q == ST_IDLE);
    assign cmd_take     = cmd_ready && cmd_valid;
    assign scale_load   = (st_q == ST_SCALE);
    assign row_in_ready = (st_q == ST_STREAM) && out_free;
    assign row_accept   = row_in_valid && row_in_ready;
    assign row_is_last  = (cnt_q == rows_lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            size_q <= SZ_W8_H8;
        end else begin
            unique case (st_q)
                ST_IDLE: if (cmd_valid) begin
                    size_q <= cmd_size;
                    cnt_q  <= '0;
                    st_q   <= ST_SCALE;
                end
                ST_SCALE: st_q <= ST_STREAM;
                ST_STREAM: if (row_accept) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (row_is_last) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R12
    cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && row_in_ready));

    // R10
    row_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_STREAM |-> cnt_q < rows_lim);

    // R10
    block_end_chk: assert property (@(posedge clk) disable iff (rst)
        row_accept && row_is_last |=> cmd_ready && !row_in_ready);

endmodule

// File: rtl/dcadd_top.sv
module dcadd_top
    import dcadd_pkg::*;
#(
    parameter int DC_W  = 12,
    parameter int LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [DC_W-1:0]        cmd_dc,
    input  logic [1:0]             cmd_size,
    input  logic                   row_in_valid,
    output logic                   row_in_ready,
    input  logic [LANES*PIX_W-1:0] row_in_data,
    output logic                   row_out_valid,
    input  logic                   row_out_ready,
    output logic [LANES*PIX_W-1:0] row_out_data,
    output logic                   row_out_last
);
    localparam int MAX_ROWS = LANES;

    logic        cmd_take, scale_load, row_accept, row_is_last, out_free;
    blk_size_e   size_q;
    pix_offset_t offset;

    dcadd_sequencer #(.MAX_ROWS(MAX_ROWS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_size     (blk_size_e'(cmd_size)),
        .row_in_valid (row_in_valid),
        .out_free     (out_free),
        .cmd_ready    (cmd_ready),
        .cmd_take     (cmd_take),
        .row_in_ready (row_in_ready),
        .scale_load   (scale_load),
        .row_accept   (row_accept),
        .row_is_last  (row_is_last),
        .size_q       (size_q)
    );

    dcadd_scaler #(.DC_W(DC_W)) u_scale (
        .clk     (clk),
        .rst     (rst),
        .capture (cmd_take),
        .dc_in   (signed'(cmd_dc)),
        .load    (scale_load),
        .size    (size_q),
        .off_q   (offset)
    );

    dcadd_row_stage #(.LANES(LANES)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .accept    (row_accept),
        .last_in   (row_is_last),
        .wide      (is_wide(size_q)),
        .off       (offset),
        .row_in    (row_in_data),
        .out_ready (row_out_ready),
        .out_free  (out_free),
        .out_valid (row_out_valid),
        .out_last  (row_out_last),
        .out_data  (row_out_data)
    );

endmodule

// File: tb/tb_dcadd_top.sv
`timescale 1ns/1ps
module tb_dcadd_top;
    localparam int DC_W = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready;
    logic [DC_W-1:0] cmd_dc;
    logic [1:0]  cmd_size;
    logic        row_in_valid, row_in_ready;
    logic [63:0] row_in_data;
    logic        row_out_valid, row_out_ready, row_out_last;
    logic [63:0] row_out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    dcadd_top #(.DC_W(DC_W), .LANES(8)) dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dc(cmd_dc), .cmd_size(cmd_size),
        .row_in_valid(row_in_valid), .row_in_ready(row_in_ready), .row_in_data(row_in_data),
        .row_out_valid(row_out_valid), .row_out_ready(row_out_ready),
        .row_out_data(row_out_data), .row_out_last(row_out_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model_off(int dc, int sz);
        int a;
        case (sz)
            0: begin a = (3*dc + 1) >>> 1;  a = (3*a + 16) >>> 5; end
            1: begin a = (3*dc + 1) >>> 1;  a = (17*a + 64) >>> 7; end
            2: begin a = (17*dc + 4) >>> 3; a = (12*a + 64) >>> 7; end
            default: begin a = (17*dc + 4) >>> 3; a = (17*a + 64) >>> 7; end
        endcase
        return a;
    endfunction

    function automatic logic [7:0] pix(int seed, int r, int l);
        return 8'((seed*37 + r*29 + l*53) & 255);
    endfunction

    function automatic logic [7:0] clampv(int v);
        if (v > 255) return 8'd255;
        if (v < 0)   return 8'd0;
        return 8'(v);
    endfunction

    // Runs one block; stall != 0 throttles row_out_ready
    task automatic run_block(input int dc, input int sz, input int seed, input int stall,
                             input string req);
        int nrows, off, width;
        logic [63:0] rows [8];
        logic [63:0] exp;
        int got;
        nrows = (sz == 0 || sz == 2) ? 8 : 4;
        width = (sz < 2) ? 8 : 4;
        off   = model_off(dc, sz);
        for (int r = 0; r < 8; r++)
            for (int l = 0; l < 8; l++)
                rows[r][l*8 +: 8] = pix(seed, r, l);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dc = DC_W'(dc); cmd_size = 2'(sz);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R12 cmd_ready low in block", {63'd0, cmd_ready}, 64'd0);
        got = 0;
        fork
            begin : snd
                for (int r = 0; r < nrows; r++) begin
                    row_in_valid = 1'b1; row_in_data = rows[r];
                    #1;
                    while (!row_in_ready) begin @(negedge clk); #1; end
                    @(negedge clk);
                end
                row_in_valid = 1'b0;
            end
            begin : rcv
                logic        hold_v;
                logic [63:0] hold_d;
                hold_v = 1'b0; hold_d = '0;
                while (got < nrows) begin
                    row_out_ready = (stall == 0) ? 1'b1 : (((cyc * 7 + stall) % 3) != 0);
                    #1;
                    if (hold_v) check("R11 held row", row_out_data, hold_d);
                    hold_v = 1'b0;
                    if (row_out_valid && !row_out_ready) begin
                        hold_v = 1'b1; hold_d = row_out_data;
                    end
                    if (row_out_valid && row_out_ready) begin
                        exp = rows[got];
                        for (int l = 0; l < width; l++)
                            exp[l*8 +: 8] = clampv(int'(rows[got][l*8 +: 8]) + off);
                        check(req, {32'd0, row_out_data[31:0]}, {32'd0, exp[31:0]});
                        if (width == 4) check("R9 upper lanes", {32'd0, row_out_data[63:32]}, {32'd0, rows[got][63:32]});
                        else check(req, {32'd0, row_out_data[63:32]}, {32'd0, exp[63:32]});
                        check("R10 last flag", {63'd0, row_out_last}, {63'd0, got == nrows - 1});
                        got++;
                    end
                    @(negedge clk);
                end
                row_out_ready = 1'b1;
            end
        join
        #1;
        check("R10 intake closed", {63'd0, row_in_ready}, 64'd0);
        check("R10 cmd_ready back", {63'd0, cmd_ready}, 64'd1);
    endtask

    task automatic t_reset();
        #1;
        check("R1 cmd_ready", {63'd0, cmd_ready}, 64'd1);
        check("R1 row_in_ready", {63'd0, row_in_ready}, 64'd0);
        check("R1 row_out_valid", {63'd0, row_out_valid}, 64'd0);
    endtask

    task automatic t_no_cmd();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            row_in_valid = 1'b1; row_in_data = 64'hFFFF_0000_1234_5678;
            #1;
            check("R12 no intake before cmd", {62'd0, row_in_ready, row_out_valid}, 64'd0);
        end
        row_in_valid = 1'b0;
    endtask

    task automatic t_sizes();
        run_block(100, 0, 1, 0, "R2 8x8");
        run_block(-300, 0, 2, 0, "R2 8x8 neg");
        run_block(150, 1, 3, 0, "R3 8w4h");
        run_block(-77, 1, 4, 0, "R3 8w4h neg");
        run_block(200, 2, 5, 0, "R4 4w8h");
        run_block(-250, 2, 6, 0, "R4 4w8h neg");
        run_block(64, 3, 7, 0, "R5 4x4");
        run_block(-130, 3, 8, 0, "R5 4x4 neg");
    endtask

    task automatic t_rounding();
        // -7 in 4x4 floors to offset -2 (truncation would give -1)
        check("R6 model", 64'(model_off(-7, 3)), 64'(-2));
        run_block(-7, 3, 9, 0, "R6 floor 4x4");
        run_block(-1, 1, 10, 0, "R6 floor 8w4h");
        run_block(-5, 2, 11, 0, "R6 floor 4w8h");
    endtask

    task automatic t_saturate();
        for (int s = 0; s < 4; s++) begin
            run_block(2047, s, 20 + s, 0, "R7 high clamp");
            run_block(-2048, s, 30 + s, 0, "R8 low clamp");
        end
    endtask

    task automatic t_backpressure();
        run_block(90, 0, 40, 1, "R11 8x8 throttled");
        run_block(-60, 2, 41, 2, "R11 4w8h throttled");
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_dc = '0; cmd_size = '0;
        row_in_valid = 1'b0; row_in_data = '0; row_out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_cmd();
        t_sizes();
        t_rounding();
        t_saturate();
        t_backpressure();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule